// File: doc/BRIEF.md
# Outbound PCI Access Address Translator

This block turns accesses on a CPU-side register bus into single PCI request descriptors: a command code, a 32-bit PCI address, byte enables and write data. The CPU sees two selectable regions. The control region holds the bridge registers. The I/O window region covers 64 KB. An access to the I/O window becomes a PCI I/O cycle, and a programmable base register supplies the upper half of its address.

Configuration cycles are started indirectly. Software first loads a configuration target register with a Type 0 target. That target carries a one-hot device select in bits 31..11, the function in bits 10..8 and the register number in bits 7..2. Software then reads or writes the configuration data register, and that access produces the configuration cycle. A plain request/acknowledge handshake stands in for the PCI master engine. At most one request is in flight at a time, and the CPU access stalls until the acknowledge returns.

Top module: `pci_out_xlat`

## Requirements
- R1: After reset, the configuration target and the I/O base both read as zero, `pci_req_valid` is low and `cpu_ready` is low.
- R2: The configuration target register sits at control offset 0x04. Writes are applied per byte lane under `cpu_be` (bit n covers data bits 8n+7..8n). Bits 1..0 always read as 0, so a write of 0x40000017 reads back as 0x40000014.
- R3: The I/O base register sits at control offset 0x10. It stores bits 31..16 of a write, and its bits 15..0 read as 0.
- R4: A write to the configuration data register (control offset 0x08) issues exactly one request with command 4'b1011. The request address is the configuration target, and the write data and byte enables are copied through.
- R5: A read of the configuration data register issues one request with command 4'b1010 to the configuration target. The CPU receives `pci_rdata` as sampled with the acknowledge.
- R6: An access to the I/O window issues one request with address {I/O base[31:16], cpu_addr[15:0]}. The command is 4'b0011 for a write and 4'b0010 for a read.
- R7: Once raised, `pci_req_valid` stays high and every request field stays unchanged until `pci_ack` is sampled high.
- R8: An access that needs no PCI cycle answers with a one-cycle `cpu_ready` on the edge after it is accepted. An access that issues a request raises `pci_req_valid` on that edge, and `cpu_ready` follows on the edge that samples `pci_ack`.
- R9: Control offsets other than 0x04, 0x08 and 0x10 read as zero, ignore writes and issue no request.
- R10: Only one request is ever outstanding. A CPU access still held during the acknowledge or response cycle starts no second request, and `cpu_ready` and `pci_req_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access strobe, held until `cpu_ready` |
| cpu_sel_reg | input | 1 | 1 selects the control region, 0 the I/O window |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 16 | Byte offset inside the selected region |
| cpu_be | input | 4 | Byte enables |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| pci_req_valid | output | 1 | Request descriptor valid |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | PCI address |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | PCI write data |
| pci_ack | input | 1 | Request accepted and completed |
| pci_rdata | input | 32 | Read data returned with `pci_ack` |

## Verification
Inputs are driven at a falling edge. Each result is read at the next falling edge, half a period after the rising edge that produced it.

A register-only access has `cpu_ready` due one rising edge after `cpu_req`. A PCI-bound access has `pci_req_valid` and its fields due after that same single edge. The bench then holds `pci_ack` back for a per-vector number of cycles and checks at each falling edge that the request stays up unchanged. It raises the acknowledge for exactly one cycle and expects `cpu_ready` with the returned data, and a dropped request, one edge later. One further falling edge confirms that no second request follows while the strobe is still held.

// File: rtl/pci_xlat_pkg.sv
package pci_xlat_pkg;
  // PCI command encodings used for outbound requests
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // control-region offsets
  localparam logic [15:0] OFS_CFG_TGT  = 16'h0004;
  localparam logic [15:0] OFS_CFG_DATA = 16'h0008;
  localparam logic [15:0] OFS_IO_BASE  = 16'h0010;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RESP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pci_xlat_regs.sv
module pci_xlat_regs
  import pci_xlat_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WIN_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take,
  input  logic [WIN_AW-1:0] ofs,
  input  logic [DW/8-1:0]   be,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     cfg_tgt,
  output logic [DW-1:0]     io_base,
  output logic [DW-1:0]     rd_data
);
  localparam int BW = DW / 8;
  localparam logic [DW-1:0] CFG_KEEP = {{(DW-2){1'b1}}, 2'b00};
  localparam logic [DW-1:0] IO_KEEP  = {{(DW-WIN_AW){1'b1}}, {WIN_AW{1'b0}}};

  logic [DW-1:0] lane_mask;
  logic [DW-1:0] cfg_q, cfg_d, io_q, io_d;
  logic          cfg_en, io_en;

  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign lane_mask[8*g +: 8] = {8{be[g]}};
  end

  always_comb begin
    cfg_en = wr_take && (ofs == OFS_CFG_TGT[WIN_AW-1:0]);
    io_en  = wr_take && (ofs == OFS_IO_BASE[WIN_AW-1:0]);
    cfg_d  = ((cfg_q & ~lane_mask) | (wdata & lane_mask)) & CFG_KEEP;
    io_d   = ((io_q  & ~lane_mask) | (wdata & lane_mask)) & IO_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      io_q  <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (io_en)  io_q  <= io_d;
    end
  end

  always_comb begin
    unique case (ofs)
      OFS_CFG_TGT[WIN_AW-1:0]: rd_data = cfg_q;
      OFS_IO_BASE[WIN_AW-1:0]: rd_data = io_q;
      default:                 rd_data = '0;
    endcase
  end

  assign cfg_tgt = cfg_q;
  assign io_base = io_q;

  // R2
  cfg_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_tgt[1:0] == 2'b00));
endmodule

// File: rtl/pci_xlat_decode.sv
module pci_xlat_decode
  import pci_xlat_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WIN_AW = 16
) (
  input  logic              sel_reg,
  input  logic              we,
  input  logic [WIN_AW-1:0] ofs,
  input  logic [DW-1:0]     cfg_tgt,
  input  logic [DW-1:0]     io_base,
  output logic              needs_pci,
  output logic [3:0]        cmd,
  output logic [DW-1:0]     addr
);
  logic is_cfg_data;

  always_comb begin
    is_cfg_data = sel_reg && (ofs == OFS_CFG_DATA[WIN_AW-1:0]);
    needs_pci   = !sel_reg || is_cfg_data;
    if (sel_reg) begin
      cmd  = we ? CMD_CFG_WR : CMD_CFG_RD;
      addr = cfg_tgt;
    end else begin
      cmd  = we ? CMD_IO_WR : CMD_IO_RD;
      addr = {io_base[DW-1:WIN_AW], ofs};
    end
  end
endmodule

// File: rtl/pci_xlat_seq.sv
module pci_xlat_seq
  import pci_xlat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            needs_pci,
  input  logic [3:0]      cmd_in,
  input  logic [DW-1:0]   addr_in,
  input  logic [DW/8-1:0] be_in,
  input  logic [DW-1:0]   wdata_in,
  input  logic [DW-1:0]   reg_rdata,
  input  logic            pci_ack,
  input  logic [DW-1:0]   pci_rdata,
  output logic            take,
  output logic            cpu_ready,
  output logic [DW-1:0]   cpu_rdata,
  output logic            pci_req_valid,
  output logic [3:0]      pci_cmd,
  output logic [DW-1:0]   pci_addr,
  output logic [DW/8-1:0] pci_be,
  output logic [DW-1:0]   pci_wdata
);
  seq_state_e st_q, st_d;
  logic       issue_en, reg_done_en, ack_en;

  always_comb begin
    take        = (st_q == SQ_IDLE) && cpu_req;
    issue_en    = take && needs_pci;
    reg_done_en = take && !needs_pci;
    ack_en      = (st_q == SQ_WAIT) && pci_ack;
    st_d        = st_q;
    unique case (st_q)
      SQ_IDLE: if (take) st_d = needs_pci ? SQ_WAIT : SQ_RESP;
      SQ_WAIT: if (pci_ack) st_d = SQ_RESP;
      SQ_RESP: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_cmd   <= '0;
      pci_addr  <= '0;
      pci_be    <= '0;
      pci_wdata <= '0;
    end else if (issue_en) begin
      pci_cmd   <= cmd_in;
      pci_addr  <= addr_in;
      pci_be    <= be_in;
      pci_wdata <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cpu_rdata <= '0;
    else if (reg_done_en) cpu_rdata <= reg_rdata;
    else if (ack_en)      cpu_rdata <= pci_rdata;
  end

  assign pci_req_valid = (st_q == SQ_WAIT);
  assign cpu_ready     = (st_q == SQ_RESP);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_ack) |=> (pci_req_valid && $stable(pci_cmd) &&
      $stable(pci_addr) && $stable(pci_be) && $stable(pci_wdata)));
  // R8
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && pci_ack) |=> (cpu_ready && !pci_req_valid));
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R10
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && pci_req_valid));
  // R10
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !pci_req_valid);
endmodule

// File: rtl/pci_out_xlat.sv
module pci_out_xlat
  import pci_xlat_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WIN_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_sel_reg,
  input  logic              cpu_we,
  input  logic [WIN_AW-1:0] cpu_addr,
  input  logic [DW/8-1:0]   cpu_be,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ready,
  output logic              pci_req_valid,
  output logic [3:0]        pci_cmd,
  output logic [DW-1:0]     pci_addr,
  output logic [DW/8-1:0]   pci_be,
  output logic [DW-1:0]     pci_wdata,
  input  logic              pci_ack,
  input  logic [DW-1:0]     pci_rdata
);
  logic          take, needs_pci, reg_wr_take;
  logic [3:0]    dec_cmd;
  logic [DW-1:0] dec_addr, cfg_tgt, io_base, reg_rdata;

  assign reg_wr_take = take && cpu_sel_reg && cpu_we;

  pci_xlat_regs #(.DW(DW), .WIN_AW(WIN_AW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_take(reg_wr_take), .ofs(cpu_addr),
    .be(cpu_be), .wdata(cpu_wdata), .cfg_tgt(cfg_tgt), .io_base(io_base),
    .rd_data(reg_rdata)
  );

  pci_xlat_decode #(.DW(DW), .WIN_AW(WIN_AW)) i_dec (
    .sel_reg(cpu_sel_reg), .we(cpu_we), .ofs(cpu_addr), .cfg_tgt(cfg_tgt),
    .io_base(io_base), .needs_pci(needs_pci), .cmd(dec_cmd), .addr(dec_addr)
  );

  pci_xlat_seq #(.DW(DW)) i_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .needs_pci(needs_pci),
    .cmd_in(dec_cmd), .addr_in(dec_addr), .be_in(cpu_be), .wdata_in(cpu_wdata),
    .reg_rdata(reg_rdata), .pci_ack(pci_ack), .pci_rdata(pci_rdata),
    .take(take), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .pci_req_valid(pci_req_valid), .pci_cmd(pci_cmd), .pci_addr(pci_addr),
    .pci_be(pci_be), .pci_wdata(pci_wdata)
  );

  // R2
  cfg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && pci_cmd[3]) |-> (pci_addr[1:0] == 2'b00));
  // R6
  io_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_cmd[3]) |-> (pci_cmd[3:1] == 3'b001));
endmodule

// File: tb/test_pci_out_xlat.sv
module test_pci_out_xlat;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 15;

  typedef struct packed {
    logic        sel;
    logic        we;
    logic [15:0] ofs;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [3:0]  dly;
    logic [31:0] rsp;
    logic        ereq;
    logic [3:0]  ecmd;
    logic [31:0] eaddr;
    logic [31:0] erd;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,16'h0004,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h00000000,8'd1},          // R1 cfg target zero
    '{1'b1,1'b0,16'h0010,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h00000000,8'd1},          // R1 io base zero
    '{1'b1,1'b1,16'h0004,4'hF,32'h40000017,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd2},          // R2 write target
    '{1'b1,1'b0,16'h0004,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h40000014,8'd2},          // R2 low bits zero
    '{1'b1,1'b1,16'h0008,4'hF,32'hCAFE0001,4'd0,32'h0,1'b1,4'hB,32'h40000014,32'h0,8'd4},   // R4 cfg write
    '{1'b1,1'b0,16'h0008,4'h3,32'h0,4'd2,32'h12345678,1'b1,4'hA,32'h40000014,32'h12345678,8'd5}, // R5 cfg read, stall
    '{1'b1,1'b1,16'h0010,4'hF,32'hABCD1234,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd3},          // R3 write base
    '{1'b1,1'b0,16'h0010,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'hABCD0000,8'd3},          // R3 low half zero
    '{1'b0,1'b1,16'h0080,4'h1,32'h00000055,4'd0,32'h0,1'b1,4'h3,32'hABCD0080,32'h0,8'd6},   // R6 io write
    '{1'b0,1'b0,16'hFFFC,4'hF,32'h0,4'd3,32'hDEADBEEF,1'b1,4'h2,32'hABCDFFFC,32'hDEADBEEF,8'd6}, // R6 io read, R7 hold
    '{1'b1,1'b1,16'h0004,4'h8,32'h08FFFFFF,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd2},          // R2 top lane only
    '{1'b1,1'b0,16'h0004,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h08000014,8'd2},          // R2 lane result
    '{1'b1,1'b1,16'h000C,4'hF,32'hFFFFFFFF,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd9},          // R9 unused write
    '{1'b1,1'b0,16'h000C,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h00000000,8'd9},          // R9 unused read
    '{1'b1,1'b0,16'h0008,4'hF,32'h0,4'd0,32'h00000000,1'b1,4'hA,32'h08000014,32'h0,8'd9}    // R9 target unchanged
  };

  logic        clk, rst_n;
  logic        cpu_req, cpu_sel_reg, cpu_we, cpu_ready, pci_req_valid, pci_ack;
  logic [15:0] cpu_addr;
  logic [3:0]  cpu_be, pci_cmd, pci_be;
  logic [31:0] cpu_wdata, cpu_rdata, pci_addr, pci_wdata, pci_rdata;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  pci_out_xlat i_pci_out_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_sel_reg(cpu_sel_reg),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .pci_req_valid(pci_req_valid),
    .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_be(pci_be), .pci_wdata(pci_wdata),
    .pci_ack(pci_ack), .pci_rdata(pci_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_access(input vec_t v);
    @(negedge clk);
    cpu_req = 1'b1; cpu_sel_reg = v.sel; cpu_we = v.we;
    cpu_addr = v.ofs; cpu_be = v.be; cpu_wdata = v.wd;
    @(negedge clk);
    if (v.ereq) begin
      check(v.rq, "req valid", {31'b0, pci_req_valid}, 32'd1);
      check(v.rq, "cmd", {28'b0, pci_cmd}, {28'b0, v.ecmd});
      check(v.rq, "addr", pci_addr, v.eaddr);
      check(v.rq, "be", {28'b0, pci_be}, {28'b0, v.be});
      if (v.we) check(v.rq, "wdata", pci_wdata, v.wd);
      check(8, "ready while waiting", {31'b0, cpu_ready}, 32'd0);
      for (int k = 0; k < int'(v.dly); k++) begin
        @(negedge clk);
        check(7, "req held", {31'b0, pci_req_valid}, 32'd1);
        check(7, "addr held", pci_addr, v.eaddr);
        check(8, "stalled", {31'b0, cpu_ready}, 32'd0);
      end
      pci_ack = 1'b1; pci_rdata = v.rsp;
      @(negedge clk);
      pci_ack = 1'b0; pci_rdata = 32'h0;
      check(8, "ready after ack", {31'b0, cpu_ready}, 32'd1);
      check(10, "req dropped", {31'b0, pci_req_valid}, 32'd0);
      if (!v.we) check(v.rq, "read data", cpu_rdata, v.erd);
    end else begin
      check(8, "ready reg", {31'b0, cpu_ready}, 32'd1);
      check(v.rq, "no req", {31'b0, pci_req_valid}, 32'd0);
      if (!v.we) check(v.rq, "reg read", cpu_rdata, v.erd);
    end
    cpu_req = 1'b0;
    @(negedge clk);
    check(8, "ready pulse", {31'b0, cpu_ready}, 32'd0);
    check(10, "no second req", {31'b0, pci_req_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_sel_reg = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_be = '0; cpu_wdata = '0; pci_ack = 1'b0; pci_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, "ready after reset", {31'b0, cpu_ready}, 32'd0);
    check(1, "valid after reset", {31'b0, pci_req_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) do_access(VECS[i]);

    // R10: strobe held through the response cycle starts nothing new
    @(negedge clk);
    cpu_req = 1'b1; cpu_sel_reg = 1'b0; cpu_we = 1'b1; cpu_addr = 16'h0100;
    cpu_be = 4'hF; cpu_wdata = 32'h1;
    @(negedge clk);
    pci_ack = 1'b1;
    @(negedge clk);
    pci_ack = 1'b0;
    check(10, "ready with held strobe", {31'b0, cpu_ready}, 32'd1);
    @(negedge clk);
    cpu_req = 1'b0;
    check(10, "no repeat from held strobe", {31'b0, pci_req_valid}, 32'd0);

    // R1: reset mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_access('{1'b1,1'b0,16'h0004,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd1});
    do_access('{1'b1,1'b0,16'h0010,4'hF,32'h0,4'd0,32'h0,1'b0,4'h0,32'h0,32'h0,8'd1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule